// File: doc/BRIEF.md
# Batch-and-Rank Priority Output Arbiter

This block picks one winner per cycle among the flits competing for a single router output port of a mesh on-chip network. Every requester presents a batch tag and an application rank. The winner is chosen in three tiers. An older batch beats a younger one. Within a batch, a higher rank beats a lower one. A round-robin pointer settles whatever is still tied. The grant is one-hot and is produced combinationally in the same cycle as the requests.

The block also holds the injection-side state for its node. A batch counter moves forward once every `BATCH_PERIOD` cycles and wraps modulo 2^`BATCH_W`. Because every node uses the same period and the same reset, all nodes agree on the current batch. A rank register holds this node's application rank, which is delivered on an external port. Nodes whose applications have fewer cache misses per instruction are treated as more critical and receive larger rank values from outside. A newly delivered rank is held back until the next batch boundary, so priorities stay the same for the whole of a batch. Until then, the previous rank stays in force.

The requester side follows valid/ready rules. Requester `i` asserts `req_valid[i]`, and its ready is `grant[i]`. A requester keeps its tags stable while it is valid and counts a transfer only in a cycle where both are high. The output side is a valid/ready pair. When `out_ready` is low, no requester is granted and the arbitration state does not move.

Top module: `batch_rank_arbiter`

## Requirements
- R1: After reset, `inj_batch` is 0, `rank_now` is 0, no grant is given, and the round-robin pointer starts at requester 0.
- R2: A batch's age is (`inj_batch` − request batch) mod 2^`BATCH_W`. A requester with a larger age wins over any requester with a smaller age, whatever their ranks.
- R3: Age is evaluated modulo the tag width. With `inj_batch` = 1, a request tagged 7 is older than one tagged 0, and that one is older than one tagged 1.
- R4: Among valid requesters of equal age, the one with the numerically larger rank wins.
- R5: When several requesters tie on both age and rank, the winner is the first of them found by scanning upward from the round-robin pointer, wrapping past `NREQ`−1. After each grant, the pointer moves to one past the winner.
- R6: While `out_ready` is low, `grant` is all zero and the round-robin pointer holds its value.
- R7: `grant` has at most one bit set, and only on a valid requester. It is nonzero whenever `out_ready` is high and any request is valid. `out_valid` equals the OR of `req_valid`.
- R8: `inj_batch` increases by 1 (mod 2^`BATCH_W`) exactly every `BATCH_PERIOD` cycles. Its first step comes `BATCH_PERIOD` rising edges after reset is released.
- R9: A value presented with `rank_load` reaches `rank_now` only at the next batch step. If several loads fall within one batch, the last one wins. A load in the same cycle as the step takes effect at that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Per-requester valid |
| req_batch | input | NREQ*BATCH_W | Batch tag per requester; requester i in bits [i*BATCH_W +: BATCH_W] |
| req_rank | input | NREQ*RANK_W | Rank tag per requester; requester i in bits [i*RANK_W +: RANK_W] |
| grant | output | NREQ | One-hot grant; serves as each requester's ready |
| out_valid | output | 1 | Some requester is valid |
| out_ready | input | 1 | Downstream can accept a flit this cycle |
| rank_load | input | 1 | Strobe to deliver a new rank |
| rank_in | input | RANK_W | Rank value delivered with `rank_load` |
| inj_batch | output | BATCH_W | Current batch, used to tag injected packets |
| rank_now | output | RANK_W | Rank currently applied to injected packets |

## Verification
Two functions can act in the same cycle: the batch step and a rank delivery. The bench places a `rank_load` exactly on the edge where `inj_batch` moves, by counting `BATCH_PERIOD`−1 edges after an observed step. It then judges that the new rank and the new batch appear together after that edge. A batch step can also land inside a stream of arbitration cycles. Each expected winner is therefore derived from the ages that apply in its own cycle. The wrap case is forced by waiting for `inj_batch` to reach 1 before presenting tags 7, 0 and 1.

// File: rtl/brarb_pkg.sv
package brarb_pkg;

  // Next index on a ring of n entries.
  function automatic int unsigned ring_next(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/brarb_epoch.sv
module brarb_epoch #(
  parameter int BATCH_PERIOD = 16,
  parameter int BATCH_W      = 3,
  parameter int RANK_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rank_load,
  input  logic [RANK_W-1:0] rank_in,
  output logic [BATCH_W-1:0] batch_now,
  output logic              step,
  output logic [RANK_W-1:0] rank_now
);
  localparam int CNT_W = (BATCH_PERIOD > 1) ? $clog2(BATCH_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BATCH_PERIOD - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [RANK_W-1:0] pend_q;
  logic              pend_v;

  assign step = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      batch_now <= '0;
      rank_now  <= '0;
      pend_q    <= '0;
      pend_v    <= 1'b0;
    end else begin
      if (step) begin
        cnt_q     <= '0;
        batch_now <= batch_now + 1'b1;
        pend_v    <= 1'b0;
        if (rank_load)   rank_now <= rank_in;
        else if (pend_v) rank_now <= pend_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (rank_load) begin
          pend_q <= rank_in;
          pend_v <= 1'b1;
        end
      end
    end
  end

  p_batch_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> batch_now == BATCH_W'($past(batch_now) + 1'b1));
  p_batch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(batch_now));
  p_rank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(rank_now));
endmodule

// File: rtl/brarb_keymax.sv
module brarb_keymax #(
  parameter int NREQ  = 10,
  parameter int KEY_W = 6
) (
  input  logic [NREQ-1:0]       valid,
  input  logic [NREQ*KEY_W-1:0] keys,
  output logic [NREQ-1:0]       match
);
  logic [KEY_W-1:0] best;

  always_comb begin
    best = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (valid[i] && keys[i*KEY_W +: KEY_W] > best) best = keys[i*KEY_W +: KEY_W];
    end
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_match
    assign match[g] = valid[g] && (keys[g*KEY_W +: KEY_W] == best);
  end
endmodule

// File: rtl/brarb_rrpick.sv
module brarb_rrpick #(
  parameter int NREQ = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] cand,
  input  logic            fire,
  output logic [NREQ-1:0] pick
);
  localparam int PTR_W = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] idx;
  logic             found;

  always_comb begin
    int j;
    pick  = '0;
    idx   = '0;
    found = 1'b0;
    for (int k = 0; k < NREQ; k++) begin
      j = int'(ptr_q) + k;
      if (j >= NREQ) j = j - NREQ;
      if (!found && cand[j]) begin
        found   = 1'b1;
        pick[j] = 1'b1;
        idx     = PTR_W'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             ptr_q <= '0;
    else if (fire && found) ptr_q <= PTR_W'(brarb_pkg::ring_next(int'(idx), NREQ));
  end

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(ptr_q));
  p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < NREQ);
  p_pick_cand_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick) && ((pick & ~cand) == '0));
endmodule

// File: rtl/batch_rank_arbiter.sv
module batch_rank_arbiter #(
  parameter int NREQ         = 10,
  parameter int BATCH_W      = 3,
  parameter int RANK_W       = 3,
  parameter int BATCH_PERIOD = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREQ-1:0]         req_valid,
  input  logic [NREQ*BATCH_W-1:0] req_batch,
  input  logic [NREQ*RANK_W-1:0]  req_rank,
  output logic [NREQ-1:0]         grant,
  output logic                    out_valid,
  input  logic                    out_ready,
  input  logic                    rank_load,
  input  logic [RANK_W-1:0]       rank_in,
  output logic [BATCH_W-1:0]      inj_batch,
  output logic [RANK_W-1:0]       rank_now
);
  localparam int KEY_W = BATCH_W + RANK_W;

  logic                  step;
  logic [NREQ*KEY_W-1:0] keys;
  logic [NREQ-1:0]       match;
  logic [NREQ-1:0]       pick;
  logic                  fire;

  brarb_epoch #(.BATCH_PERIOD(BATCH_PERIOD), .BATCH_W(BATCH_W), .RANK_W(RANK_W)) u_epoch (
    .clk(clk), .rst_n(rst_n), .rank_load(rank_load), .rank_in(rank_in),
    .batch_now(inj_batch), .step(step), .rank_now(rank_now));

  // Priority key: batch age (modular distance from the current batch) above rank.
  for (genvar g = 0; g < NREQ; g++) begin : g_key
    logic [BATCH_W-1:0] age;
    assign age = inj_batch - req_batch[g*BATCH_W +: BATCH_W];
    assign keys[g*KEY_W +: KEY_W] = {age, req_rank[g*RANK_W +: RANK_W]};
  end

  brarb_keymax #(.NREQ(NREQ), .KEY_W(KEY_W)) u_max (
    .valid(req_valid), .keys(keys), .match(match));

  assign out_valid = |req_valid;
  assign fire      = out_valid && out_ready;

  brarb_rrpick #(.NREQ(NREQ)) u_rr (
    .clk(clk), .rst_n(rst_n), .cand(match), .fire(fire), .pick(pick));

  assign grant = out_ready ? pick : '0;

  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_grant_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_valid) == '0);
  p_grant_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && (|req_valid)) |-> $countones(grant) == 1);
  p_no_grant_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> grant == '0);
endmodule

// File: tb/sim_batch_rank_arbiter.sv
`timescale 1ns/1ps
module sim_batch_rank_arbiter;
  localparam int N  = 5;
  localparam int BW = 3;
  localparam int RW = 3;
  localparam int T  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N*BW-1:0] req_batch = '0;
  logic [N*RW-1:0] req_rank  = '0;
  logic [N-1:0]    grant;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic            rank_load = 1'b0;
  logic [RW-1:0]   rank_in   = '0;
  logic [BW-1:0]   inj_batch;
  logic [RW-1:0]   rank_now;

  always #2.5 clk = ~clk;

  batch_rank_arbiter #(.NREQ(N), .BATCH_W(BW), .RANK_W(RW), .BATCH_PERIOD(T)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_batch(req_batch),
    .req_rank(req_rank), .grant(grant), .out_valid(out_valid), .out_ready(out_ready),
    .rank_load(rank_load), .rank_in(rank_in), .inj_batch(inj_batch), .rank_now(rank_now));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard
  typedef struct { logic [N-1:0] g; logic ov; string tag; } item_t;
  item_t exp_q[$];
  event  mon_ev;
  int    aage[N];
  int    arank[N];
  int    m_ptr = 0;

  always begin
    item_t it;
    @(mon_ev);
    #1;
    it = exp_q.pop_front();
    check(grant == it.g, it.tag, int'(grant), int'(it.g));
    check(out_valid == it.ov, "R7", int'(out_valid), int'(it.ov));
  end

  function automatic int ref_idx(logic [N-1:0] v, int ptr);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (v[i] && aage[i]*8 + arank[i] > best) best = aage[i]*8 + arank[i];
    for (int k = 0; k < N; k++) begin
      int j = (ptr + k) % N;
      if (v[j] && aage[j]*8 + arank[j] == best) return j;
    end
    return -1;
  endfunction

  task automatic drive_case(logic [N-1:0] v, logic rdy, string tag);
    item_t it;
    int w;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      req_batch[i*BW +: BW] = BW'((int'(inj_batch) - aage[i]) & 7);
      req_rank[i*RW +: RW]  = RW'(arank[i]);
    end
    req_valid = v;
    out_ready = rdy;
    w = ref_idx(v, m_ptr);
    it.g   = (rdy && w >= 0) ? N'(1) << w : '0;
    it.ov  = |v;
    it.tag = tag;
    exp_q.push_back(it);
    -> mon_ev;
    @(posedge clk);
    if (rdy && w >= 0) m_ptr = (w + 1) % N;
  endtask

  task automatic set_all(int age, int rank);
    for (int i = 0; i < N; i++) begin aage[i] = age; arank[i] = rank; end
  endtask

  task automatic sync_step();
    logic [BW-1:0] b = inj_batch;
    do begin @(posedge clk); #1; end while (inj_batch == b);
  endtask

  // R8 monitor: period and increment of the batch counter
  int cyc = 0;
  logic [BW-1:0] last_b = '0;
  always begin
    @(posedge clk);
    #1;
    if (rst_n) begin
      cyc++;
      if (inj_batch != last_b) begin
        check(cyc == T, "R8 period", cyc, T);
        check(inj_batch == BW'(last_b + 1'b1), "R8 step", int'(inj_batch), int'(BW'(last_b + 1'b1)));
        cyc = 0;
        last_b = inj_batch;
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    check(inj_batch == 0, "R1 batch", int'(inj_batch), 0);
    check(rank_now == 0, "R1 rank", int'(rank_now), 0);
    check(grant == 0, "R1 grant", int'(grant), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5: equal keys, pointer starts at 0, rotates one past each winner
    set_all(0, 2);
    for (int n = 0; n < 7; n++) drive_case(5'b11111, 1'b1, "R5 rotate");
    drive_case(5'b10010, 1'b1, "R5 sparse");
    drive_case(5'b10010, 1'b1, "R5 sparse");

    // R4: highest rank within same batch, ties fall to rr
    set_all(0, 0);
    arank[0] = 1; arank[1] = 5; arank[2] = 3; arank[3] = 5; arank[4] = 2;
    drive_case(5'b11111, 1'b1, "R4 rank");
    drive_case(5'b11111, 1'b1, "R4 rank tie");
    drive_case(5'b10101, 1'b1, "R4 rank");

    // R2: older batch beats higher rank
    set_all(0, 7);
    aage[0] = 1; arank[0] = 0;
    drive_case(5'b11111, 1'b1, "R2 oldest");
    aage[2] = 3; arank[2] = 0; aage[4] = 2;
    drive_case(5'b10101, 1'b1, "R2 oldest");

    // R6: stall keeps pointer, no grant
    set_all(0, 4);
    drive_case(5'b11111, 1'b0, "R6 stall");
    drive_case(5'b11111, 1'b0, "R6 stall");
    drive_case(5'b11111, 1'b1, "R6 resume");

    // R7: nothing valid
    drive_case(5'b00000, 1'b1, "R7 idle");

    // R3: wrap, wait until batch is 1 then tags 7,0,1
    while (inj_batch != 1) sync_step();
    set_all(0, 7);
    aage[1] = 2; arank[1] = 0;   // tag 7
    aage[3] = 1; arank[3] = 6;   // tag 0
    drive_case(5'b11111, 1'b1, "R3 wrap");
    drive_case(5'b11101, 1'b1, "R3 wrap");

    // R9: load mid-batch is deferred, last load wins
    @(negedge clk);
    req_valid = '0;
    sync_step();
    @(negedge clk); rank_load = 1'b1; rank_in = 3'd5;
    @(negedge clk); rank_load = 1'b0;
    check(rank_now == 0, "R9 deferred", int'(rank_now), 0);
    @(negedge clk); rank_load = 1'b1; rank_in = 3'd6;
    @(negedge clk); rank_load = 1'b0;
    check(rank_now == 0, "R9 deferred", int'(rank_now), 0);
    sync_step();
    check(rank_now == 6, "R9 last wins", int'(rank_now), 6);

    // R9: load coinciding with the batch step
    repeat (T - 1) @(posedge clk);
    @(negedge clk); rank_load = 1'b1; rank_in = 3'd3;
    @(posedge clk); #1;
    check(rank_now == 3, "R9 same-cycle", int'(rank_now), 3);
    check(cyc == 0, "R9 same-cycle step", cyc, 0);
    @(negedge clk); rank_load = 1'b0;

    repeat (3 * T) @(posedge clk);
    #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule